// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a register-mapped I/O port for four pins. A simple synchronous register port lets software program three registers. The output latch holds the value driven onto output pins. The direction register picks, per pin, whether the pin is driven. The pull-up register asks for weak pull-ups on input pins. The block drives an output enable, an output value and a pull-up enable for each pin. The pad itself sits outside.

A read of the output latch address is mixed bit by bit. A pin set as output returns the stored latch bit. A pin set as input returns its pin level, taken through a two-flop synchronizer. The upper four bits of the latch and pull-up registers are fixed at 1. Pull-ups only take effect on input pins, and only when the chip's operating mode is 5, 6 or 7.

A power-state machine tracks two standby requests. Its states are RUN, SW_SBY and HW_SBY. It moves RUN to SW_SBY when only the software request is high. It moves from any state to HW_SBY when the hardware request is high. It moves HW_SBY to SW_SBY when the hardware request drops while the software request stays high. It moves HW_SBY or SW_SBY to RUN when no request is high. In HW_SBY the registers are held at their reset values. In SW_SBY they keep their contents. Bus writes are refused in both standby states.

Top module: `gpio4_port`

## Requirements
- R1: After reset, the latch (address 0) reads 0xF0 with all pins low, direction (address 1) reads 0x00, pull-up (address 2) reads 0xF0, and pin_oe is 0.
- R2: Bits 7..4 of the latch and pull-up registers ignore writes and always read as 1.
- R3: For a pin whose direction bit is 1, a read of address 0 returns the stored latch bit whatever the pin level.
- R4: For a pin whose direction bit is 0, a read of address 0 returns the pin level. The level counts if it was stable for at least three clock edges before the edge that samples the read.
- R5: pin_oe equals the direction bits and pin_out equals the low four latch bits.
- R6: pin_pu[i] is 1 exactly when direction bit i is 0, pull-up bit i is 1, and mode is 5, 6 or 7.
- R7: In hardware standby, the latch and pull-up registers return to 0xF0 and direction returns to 0x00, and writes are ignored.
- R8: In software standby, all registers keep their contents and writes are ignored.
- R9: Address 3 is unmapped: a read returns 0x00 and a write changes no register.
- R10: rdata is registered. It shows, one edge after a cycle with rd_en high, the register value from before any write in that same cycle. After a cycle with rd_en low it shows 0x00.
- R11: The hardware request takes priority over the software request. Dropping the hardware request while the software request is high gives SW_SBY with the registers still at their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address (0 latch, 1 direction, 2 pull-up, 3 unmapped) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| mode | input | 3 | Chip operating mode |
| sw_stby | input | 1 | Software standby request |
| hw_stby | input | 1 | Hardware standby request |
| pin_in | input | 4 | Pin levels from the pads |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin output value |
| pin_pu | output | 4 | Per-pin pull-up enable |

## Verification
A write and a read of the latch register can land in the same cycle. The bench provokes this by raising wr_en and rd_en together on address 0. It expects the read to return the latch value from before the write, and a read on the next cycle to return the new value. A second collision is a write that arrives in the first cycle of a standby request. The bench expects the write to go through, because the state machine changes state one edge later. A write one cycle after that is expected to be refused.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SW_SBY = 2'd1,
        ST_HW_SBY = 2'd2
    } pwr_state_t;

    localparam int ADR_LATCH = 0;
    localparam int ADR_DIR   = 1;
    localparam int ADR_PULL  = 2;

    localparam int PU_MODE_MIN = 5;

endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio4_stby_fsm.sv
module gpio4_stby_fsm
    import gpio4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_stby,
    input  logic       hw_stby,
    output pwr_state_t state,
    output logic       regs_clear,
    output logic       wr_allow
);
    pwr_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (hw_stby)      nxt = ST_HW_SBY;
                else if (sw_stby) nxt = ST_SW_SBY;
            end
            ST_SW_SBY: begin
                if (hw_stby)       nxt = ST_HW_SBY;
                else if (!sw_stby) nxt = ST_RUN;
            end
            ST_HW_SBY: begin
                if (!hw_stby)     nxt = sw_stby ? ST_SW_SBY : ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        regs_clear = 1'b0;
        wr_allow   = 1'b0;
        unique case (state)
            ST_RUN:    wr_allow   = 1'b1;
            ST_SW_SBY: wr_allow   = 1'b0;
            ST_HW_SBY: regs_clear = 1'b1;
            default:   wr_allow   = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
#(
    parameter int PINS = 4,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            regs_clear,
    input  logic            wr_allow,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [PINS-1:0] wbits,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] pull_q
);
    logic wr_latch, wr_dir, wr_pull;

    always_comb begin
        wr_latch = wr_en && wr_allow && (addr == AW'(ADR_LATCH));
        wr_dir   = wr_en && wr_allow && (addr == AW'(ADR_DIR));
        wr_pull  = wr_en && wr_allow && (addr == AW'(ADR_PULL));
    end

    for (genvar i = 0; i < PINS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                latch_q[i] <= 1'b0;
                dir_q[i]   <= 1'b0;
                pull_q[i]  <= 1'b0;
            end else if (regs_clear) begin
                latch_q[i] <= 1'b0;
                dir_q[i]   <= 1'b0;
                pull_q[i]  <= 1'b0;
            end else begin
                if (wr_latch) latch_q[i] <= wbits[i];
                if (wr_dir)   dir_q[i]   <= wbits[i];
                if (wr_pull)  pull_q[i]  <= wbits[i];
            end
        end
    end
endmodule

// File: rtl/gpio4_rdmux.sv
module gpio4_rdmux
    import gpio4_pkg::*;
#(
    parameter int PINS = 4,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] pull_q,
    input  logic [PINS-1:0] pin_s,
    output logic [DW-1:0]   rdata
);
    localparam int RSV = DW - PINS;

    logic [PINS-1:0] mixed;
    logic [DW-1:0]   rd_val;

    for (genvar i = 0; i < PINS; i++) begin : g_mix
        assign mixed[i] = dir_q[i] ? latch_q[i] : pin_s[i];
    end

    always_comb begin
        rd_val = '0;
        if (addr == AW'(ADR_LATCH))     rd_val = {{RSV{1'b1}}, mixed};
        else if (addr == AW'(ADR_DIR))  rd_val = {{RSV{1'b0}}, dir_q};
        else if (addr == AW'(ADR_PULL)) rd_val = {{RSV{1'b1}}, pull_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
        else            rdata <= '0;
    end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio4_pkg::*;
#(
    parameter int PINS        = 4,
    parameter int DW          = 8,
    parameter int AW          = 2,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    input  logic [MODE_W-1:0] mode,
    input  logic              sw_stby,
    input  logic              hw_stby,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_pu
);
    pwr_state_t      state;
    logic            regs_clear, wr_allow;
    logic [PINS-1:0] latch_q, dir_q, pull_q, pin_s;
    logic            pu_mode;
    logic            rsv_unused;

    assign rsv_unused = ^wdata[DW-1:PINS];

    gpio4_stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_stby    (sw_stby),
        .hw_stby    (hw_stby),
        .state      (state),
        .regs_clear (regs_clear),
        .wr_allow   (wr_allow)
    );

    gpio4_regs #(.PINS(PINS), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs_clear (regs_clear),
        .wr_allow   (wr_allow),
        .wr_en      (wr_en),
        .addr       (addr),
        .wbits      (wdata[PINS-1:0]),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .pull_q     (pull_q)
    );

    gpio4_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    gpio4_rdmux #(.PINS(PINS), .DW(DW), .AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .pin_s   (pin_s),
        .rdata   (rdata)
    );

    assign pu_mode = (int'(mode) >= PU_MODE_MIN);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pin_oe[i]  = dir_q[i];
        assign pin_out[i] = latch_q[i];
        assign pin_pu[i]  = pu_mode && !dir_q[i] && pull_q[i];
    end
endmodule

// File: rtl/gpio4_port_chk.sv
module gpio4_port_chk #(
    parameter int PINS   = 4,
    parameter int DW     = 8,
    parameter int AW     = 2,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     addr,
    input logic              rd_en,
    input logic [DW-1:0]     rdata,
    input logic [MODE_W-1:0] mode,
    input logic              sw_stby,
    input logic              hw_stby,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pin_out
);
    // R2
    rsv_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == AW'(0) || addr == AW'(2))) |=> (rdata[DW-1:PINS] == '1));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(3)) |=> (rdata == '0));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    // R7
    hw_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby && $past(hw_stby) && $past(hw_stby, 2)) |-> (pin_oe == '0));

    // R8
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && $past(sw_stby) && !hw_stby && !$past(hw_stby))
        |=> ($stable(pin_out) && $stable(pin_oe)));

    // R6
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mode) < 5) |-> (gpio4_port.pin_pu == '0));

    // R6
    pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gpio4_port.pin_pu & pin_oe) == '0));
endmodule

bind gpio4_port gpio4_port_chk #(.PINS(PINS), .DW(DW), .AW(AW), .MODE_W(MODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .mode    (mode),
    .sw_stby (sw_stby),
    .hw_stby (hw_stby),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
);

// File: tb/sim_gpio4_port.sv
module sim_gpio4_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [2:0] mode = 3'd0;
    logic       sw_stby = 1'b0;
    logic       hw_stby = 1'b0;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_oe, pin_out, pin_pu;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       pend = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    gpio4_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .mode(mode), .sw_stby(sw_stby),
        .hw_stby(hw_stby), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pu(pin_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(posedge clk) pend <= rd_en;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected read", rdata, 8'h00);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++; total++;
                $display("FAIL R11 watchdog actual=timeout expected=finish");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 pin_oe", {4'h0, pin_oe}, 8'h00);
        rd(2'd0, 8'hF0, "R1 latch");
        rd(2'd1, 8'h00, "R1 dir");
        rd(2'd2, 8'hF0, "R1 pull");
        idle(1);
        chk("R10 idle rdata", rdata, 8'h00);

        // R2 reserved bits
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'h0F, "R2 dir low bits only");
        wr(2'd0, 8'h0A);
        rd(2'd0, 8'hFA, "R2 latch upper forced");
        wr(2'd2, 8'h05);
        rd(2'd2, 8'hF5, "R2 pull upper forced");

        // R3 output pins ignore pin level
        pin_in = 4'h5;
        idle(4);
        rd(2'd0, 8'hFA, "R3 output read");
        // R5
        chk("R5 pin_out", {4'h0, pin_out}, 8'h0A);
        chk("R5 pin_oe", {4'h0, pin_oe}, 8'h0F);

        // R4 mixed direction
        wr(2'd1, 8'h03);
        pin_in = 4'hC;
        idle(3);
        rd(2'd0, 8'hFE, "R4 mixed high pins");
        pin_in = 4'h0;
        idle(3);
        rd(2'd0, 8'hF2, "R4 mixed low pins");
        chk("R5 pin_oe mixed", {4'h0, pin_oe}, 8'h03);

        // R6 pull-up gating
        mode = 3'd5; #1;
        chk("R6 mode5", {4'h0, pin_pu}, 8'h04);
        mode = 3'd4; #1;
        chk("R6 mode4", {4'h0, pin_pu}, 8'h00);
        mode = 3'd7; #1;
        chk("R6 mode7", {4'h0, pin_pu}, 8'h04);
        wr(2'd2, 8'h0F);
        wr(2'd1, 8'h00);
        mode = 3'd6; #1;
        chk("R6 all inputs", {4'h0, pin_pu}, 8'h0F);

        // R9 unmapped
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R9 unmapped read");
        rd(2'd1, 8'h00, "R9 dir untouched");
        rd(2'd2, 8'hFF, "R9 pull untouched");

        // R10 same-cycle read and write
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h03);
        rdwr(2'd0, 8'h0C, 8'hF3, "R10 read sees old value");
        rd(2'd0, 8'hFC, "R10 new value after write");

        // R8 software standby: write in first cycle passes, later refused
        @(negedge clk);
        sw_stby = 1'b1; addr = 2'd0; wdata = 8'h09; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr(2'd0, 8'h06);
        rd(2'd0, 8'hF9, "R8 write refused in sw standby");
        wr(2'd2, 8'h00);
        rd(2'd2, 8'hFF, "R8 pull retained");
        chk("R8 pin_out kept", {4'h0, pin_out}, 8'h09);
        sw_stby = 1'b0;
        idle(2);
        wr(2'd0, 8'h06);
        rd(2'd0, 8'hF6, "R8 write after leaving standby");

        // R7 hardware standby
        hw_stby = 1'b1;
        idle(3);
        rd(2'd1, 8'h00, "R7 dir reset");
        rd(2'd2, 8'hF0, "R7 pull reset");
        rd(2'd0, 8'hF0, "R7 latch reset");
        chk("R7 pin_oe off", {4'h0, pin_oe}, 8'h00);
        wr(2'd1, 8'h0F);
        rd(2'd1, 8'h00, "R7 write ignored");

        // R11 priority and HW to SW transition
        sw_stby = 1'b1;
        idle(2);
        wr(2'd1, 8'h05);
        rd(2'd1, 8'h00, "R11 hw wins over sw");
        hw_stby = 1'b0;
        idle(2);
        wr(2'd1, 8'h05);
        rd(2'd1, 8'h00, "R11 sw standby after hw");
        rd(2'd2, 8'hF0, "R11 regs still reset");
        sw_stby = 1'b0;
        idle(2);
        wr(2'd1, 8'h05);
        rd(2'd1, 8'h05, "R11 back to run");

        idle(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule